// File: doc/BRIEF.md
# Highway and Farm Road Signal Controller

This block sequences the lights where a busy highway crosses a lightly used farm road. The highway keeps a green light until a vehicle is waiting on the farm road and a long minimum interval has passed. The farm road then gets a green light until it empties or the long interval runs out. Each change of green passes through a yellow phase that lasts for a short interval. One clock drives a registered four-state machine and an interval counter. The counter restarts each time the machine changes state, so every interval is measured from entry into the current state.

The inputs are a clock, a synchronous active-low reset and one vehicle sensor on the farm road. The outputs are a 2-bit light code for each road and a one-cycle pulse that marks each state change. The short and long intervals are parameters counted in clock cycles. In each state the counter counts up from zero, one step per cycle. A timed exit is taken in the cycle where the count equals the interval length. A state held by a timeout therefore lasts interval + 1 cycles.

Top module: `hwy_farm_signal_ctrl`

## Requirements
- R1: While reset is low at a clock edge, the controller enters the highway-green state and clears its interval count. After reset is released, the highway holds green for at least LONG_CYC + 1 cycles even with a vehicle waiting.
- R2: The light codes are green = 0, red = 1 and yellow = 2. At least one of the two roads shows red at all times.
- R3: In highway-green (highway 0, farm 1), the state is held for as long as the farm sensor is low, however long that lasts.
- R4: In highway-green with a vehicle waiting, the controller leaves for highway-yellow in the cycle where the count since entry reaches LONG_CYC. A vehicle that arrives after the count has already reached LONG_CYC causes the change in the same cycle.
- R5: Highway-yellow (highway 2, farm 1) lasts SHORT_CYC + 1 cycles and is followed by farm-green.
- R6: In farm-green (highway 1, farm 0), the controller leaves for farm-yellow in the same cycle the farm sensor goes low.
- R7: In farm-green with a vehicle still waiting, the controller leaves for farm-yellow in the cycle where the count since entry reaches LONG_CYC.
- R8: Farm-yellow (highway 1, farm 2) lasts SHORT_CYC + 1 cycles and is followed by highway-green.
- R9: The timer-start output is 1 in exactly the cycles in which a state change is taken, and the lights change at the next clock edge. When it is 0, the lights stay the same at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| farm_car | input | 1 | Vehicle present on the farm road |
| hwy_light | output | 2 | Highway light code (0 green, 1 red, 2 yellow) |
| farm_light | output | 2 | Farm road light code (0 green, 1 red, 2 yellow) |
| tmr_start | output | 1 | High in the cycle a state change is taken |

## Verification
A wrong state register shows at the light outputs at the next clock edge, because both light codes are decoded directly from the state. A wrong interval count does not show at once. It shows as a yellow or green phase that ends early or late, so the bench counts the exact length of every timed phase. It also checks that the start pulse appears in the same cycle the sensor input changes, because that is how a broken exit condition would show.

// File: rtl/hfc_pkg.sv
// Shared types for the highway/farm signal controller.
// Assumes: state and light codes are fixed; other blocks decode them.
package hfc_pkg;

    typedef enum logic [1:0] {
        ST_HWY_GO   = 2'd0,
        ST_FARM_WARN = 2'd1,
        ST_HWY_WARN = 2'd2,
        ST_FARM_GO  = 2'd3
    } ctrl_state_t;

    typedef enum logic [1:0] {
        LT_GREEN  = 2'd0,
        LT_RED    = 2'd1,
        LT_YELLOW = 2'd2
    } light_code_t;

endpackage

// File: rtl/hfc_interval_timer.sv
// Interval counter measured from the last restart pulse.
// Assumes: LONG_CYC >= SHORT_CYC; count saturates at LONG_CYC.
module hfc_interval_timer #(
    parameter int SHORT_CYC = 3,
    parameter int LONG_CYC  = 10,
    parameter int CNT_W     = $clog2(LONG_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic short_done,
    output logic long_done
);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYC);

    logic [CNT_W-1:0] elapsed;

    // Count cycles since the last restart, holding at the long limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            elapsed <= '0;
        end else if (elapsed != LONG_LIM) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Compare the count against both interval lengths.
    always_comb begin
        short_done = (elapsed >= SHORT_LIM);
        long_done  = (elapsed >= LONG_LIM);
    end
endmodule

// File: rtl/hfc_next_state.sv
// Combinational transition logic for the four-state signal sequence.
// Assumes: the timeout flags are measured from entry into the current state.
module hfc_next_state
    import hfc_pkg::*;
(
    input  ctrl_state_t cur,
    input  logic        farm_car,
    input  logic        short_done,
    input  logic        long_done,
    output ctrl_state_t nxt,
    output logic        change
);
    // Choose the successor state and flag a transition.
    always_comb begin
        nxt    = cur;
        change = 1'b0;
        unique case (cur)
            ST_HWY_GO: begin
                if (farm_car && long_done) begin
                    nxt    = ST_HWY_WARN;
                    change = 1'b1;
                end
            end
            ST_HWY_WARN: begin
                if (short_done) begin
                    nxt    = ST_FARM_GO;
                    change = 1'b1;
                end
            end
            ST_FARM_GO: begin
                if (!farm_car || long_done) begin
                    nxt    = ST_FARM_WARN;
                    change = 1'b1;
                end
            end
            ST_FARM_WARN: begin
                if (short_done) begin
                    nxt    = ST_HWY_GO;
                    change = 1'b1;
                end
            end
            default: begin
                nxt    = ST_HWY_GO;
                change = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/hfc_light_decode.sv
// Maps the controller state onto the two road light codes.
// Assumes: the green or yellow road is always paired with red on the other.
module hfc_light_decode
    import hfc_pkg::*;
(
    input  ctrl_state_t cur,
    output light_code_t hwy,
    output light_code_t farm
);
    // Decode one light pair per state.
    always_comb begin
        hwy  = LT_RED;
        farm = LT_RED;
        unique case (cur)
            ST_HWY_GO:    hwy  = LT_GREEN;
            ST_HWY_WARN:  hwy  = LT_YELLOW;
            ST_FARM_GO:   farm = LT_GREEN;
            ST_FARM_WARN: farm = LT_YELLOW;
            default:      hwy  = LT_RED;
        endcase
    end
endmodule

// File: rtl/hwy_farm_signal_ctrl.sv
// Top level: state register, transition logic, interval timer, light decode.
// Assumes: synchronous active-low reset; interval lengths are in clock cycles.
module hwy_farm_signal_ctrl
    import hfc_pkg::*;
#(
    parameter int SHORT_CYC = 3,
    parameter int LONG_CYC  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       farm_car,
    output logic [1:0] hwy_light,
    output logic [1:0] farm_light,
    output logic       tmr_start
);
    localparam int CNT_W = $clog2(LONG_CYC + 1);

    ctrl_state_t state_q;
    ctrl_state_t state_d;
    light_code_t hwy_code;
    light_code_t farm_code;
    logic        short_done;
    logic        long_done;
    logic        change;

    // Hold the current state; reset lands on highway-green.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HWY_GO;
        end else begin
            state_q <= state_d;
        end
    end

    hfc_interval_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (change),
        .short_done (short_done),
        .long_done  (long_done)
    );

    hfc_next_state u_next (
        .cur        (state_q),
        .farm_car   (farm_car),
        .short_done (short_done),
        .long_done  (long_done),
        .nxt        (state_d),
        .change     (change)
    );

    hfc_light_decode u_lights (
        .cur  (state_q),
        .hwy  (hwy_code),
        .farm (farm_code)
    );

    // Drive the output ports.
    always_comb begin
        hwy_light  = hwy_code;
        farm_light = farm_code;
        tmr_start  = change;
    end
endmodule

// File: rtl/hwy_farm_signal_ctrl_chk.sv
// Checker for the signal controller, observing its ports only.
// Assumes: same parameters as the bound instance.
module hwy_farm_signal_ctrl_chk #(
    parameter int SHORT_CYC = 3,
    parameter int LONG_CYC  = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       farm_car,
    input logic [1:0] hwy_light,
    input logic [1:0] farm_light,
    input logic       tmr_start
);
    localparam int SW = $clog2(LONG_CYC + 2);
    logic [SW-1:0] since;

    // Count cycles since the last observed start pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || tmr_start) begin
            since <= '0;
        end else if (since != SW'(LONG_CYC + 1)) begin
            since <= since + 1'b1;
        end
    end

    p_reset_hwy_green_r1: assert property (@(posedge clk)
        !rst_n |=> (hwy_light == 2'd0 && farm_light == 2'd1));

    p_one_red_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_light == 2'd1) || (farm_light == 2'd1));

    p_hold_no_car_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_light == 2'd0 && !farm_car) |-> !tmr_start);

    p_long_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_light == 2'd0 && tmr_start) |-> (since >= SW'(LONG_CYC)));

    p_hwy_yellow_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_light == 2'd2 && tmr_start) |=> (farm_light == 2'd0));

    p_farm_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (farm_light == 2'd0 && !farm_car) |-> tmr_start);

    p_farm_yellow_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (farm_light == 2'd2 && tmr_start) |=> (hwy_light == 2'd0));

    p_start_changes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |=> ({hwy_light, farm_light} != $past({hwy_light, farm_light})));

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_start && $past(rst_n)) |=> $stable({hwy_light, farm_light}));
endmodule

bind hwy_farm_signal_ctrl hwy_farm_signal_ctrl_chk #(
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .farm_car   (farm_car),
    .hwy_light  (hwy_light),
    .farm_light (farm_light),
    .tmr_start  (tmr_start)
);

// File: tb/hwy_farm_signal_ctrl_tb.sv
// Directed bench for the signal controller; one task per scenario.
module hwy_farm_signal_ctrl_tb;
    localparam int SHORT_CYC = 3;
    localparam int LONG_CYC  = 10;
    localparam logic [1:0] GRN = 2'd0;
    localparam logic [1:0] RED = 2'd1;
    localparam logic [1:0] YEL = 2'd2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       farm_car = 1'b0;
    logic [1:0] hwy_light;
    logic [1:0] farm_light;
    logic       tmr_start;
    int         n_checks = 0;
    int         n_errors = 0;
    logic       done = 1'b0;

    always #10 clk = ~clk;

    hwy_farm_signal_ctrl #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .farm_car   (farm_car),
        .hwy_light  (hwy_light),
        .farm_light (farm_light),
        .tmr_start  (tmr_start)
    );

    // Compare all three outputs against expected values.
    task automatic check_out(input logic [1:0] eh, input logic [1:0] ef,
                             input logic es, input string tag);
        n_checks++;
        if (hwy_light !== eh || farm_light !== ef || tmr_start !== es) begin
            n_errors++;
            $display("FAIL %s: got hwy=%0d farm=%0d start=%0b, expected hwy=%0d farm=%0d start=%0b",
                     tag, hwy_light, farm_light, tmr_start, eh, ef, es);
        end
    endtask

    // Advance one cycle; sample 1 ns after the falling edge.
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // A phase: 'hold' cycles without a start pulse, then one cycle with it.
    task automatic run_phase(input logic [1:0] eh, input logic [1:0] ef,
                             input int hold, input string tag);
        for (int i = 0; i < hold; i++) begin
            check_out(eh, ef, 1'b0, tag);
            step();
        end
        check_out(eh, ef, 1'b1, tag);
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        farm_car = 1'b0;
        step();
        step();
        check_out(GRN, RED, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        #1;
        check_out(GRN, RED, 1'b0, "R1 after release");
    endtask

    task automatic t_hwy_idle();
        farm_car = 1'b0;
        for (int i = 0; i < 3 * LONG_CYC; i++) begin
            check_out(GRN, RED, 1'b0, "R3 no car holds highway green");
            step();
        end
    endtask

    task automatic t_late_car();
        farm_car = 1'b1;
        #1;
        run_phase(GRN, RED, 0, "R4 late car after long timeout");
    endtask

    task automatic t_full_cycle_car();
        run_phase(YEL, RED, SHORT_CYC, "R5 highway yellow");
        run_phase(RED, GRN, LONG_CYC, "R7 farm green long timeout");
        run_phase(RED, YEL, SHORT_CYC, "R8 farm yellow");
        run_phase(GRN, RED, LONG_CYC, "R4 car waiting before long timeout");
        run_phase(YEL, RED, SHORT_CYC, "R5 highway yellow again");
    endtask

    task automatic t_farm_empties();
        check_out(RED, GRN, 1'b0, "R6 farm green with car");
        step();
        check_out(RED, GRN, 1'b0, "R6 farm green with car");
        step();
        farm_car = 1'b0;
        #1;
        check_out(RED, GRN, 1'b1, "R6 farm empties");
        step();
        run_phase(RED, YEL, SHORT_CYC, "R8 farm yellow after empty");
        for (int i = 0; i < 4; i++) begin
            check_out(GRN, RED, 1'b0, "R9 back to highway green");
            step();
        end
    endtask

    task automatic t_reset_mid();
        int guard;
        farm_car = 1'b1;
        guard = 0;
        while (farm_light != GRN && guard < 100) begin
            step();
            guard++;
        end
        check_out(RED, GRN, 1'b0, "R1 reached farm green before reset");
        rst_n = 1'b0;
        step();
        check_out(GRN, RED, 1'b0, "R1 reset from farm green");
        step();
        rst_n = 1'b1;
        #1;
        run_phase(GRN, RED, LONG_CYC, "R1 counter cleared by reset");
        check_out(YEL, RED, 1'b0, "R2 highway yellow code");
    endtask

    initial begin
        #1;
        t_reset();
        t_hwy_idle();
        t_late_car();
        t_full_cycle_car();
        t_farm_empties();
        t_reset_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule